// File: doc/BRIEF.md
# Turbo Frequency Step Controller

This block runs a closed control loop that chooses a single core clock ratio, counted in whole frequency bins of 133.33 MHz, for a group of cores that share one clock. On every evaluation tick it counts how many cores sit in a shallow power state, looks up how far above the base ratio that many cores may run, and moves the ratio by at most one bin. It moves up only while the operating system asks for maximum performance and the temperature, current and power comparators are all clear. It moves down while any limit is exceeded, while the ratio sits above a ceiling that has fallen, or while the performance request is gone.

The evaluation period is programmable in clock cycles. The ratio, together with a one-cycle change strobe, is the only output. Both feed the clock generator, and every active core takes the same value. The sensors, the PLL and the voltage regulation sit outside the block. Limit violations arrive as synchronous flags. All pins are plain control and status levels: no data streams through the block, so it has no valid/ready handshake.

Top module: `turbo_step_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the ratio equals the base ratio input and the change strobe is low.
- R2: Each core has a 2-bit state code in bits [2i+1:2i]. Codes 0 and 1 (running and halted) count that core as active. Codes 2 and 3 (sleep and off) count it as inactive.
- R3: The ceiling is the base ratio plus boost table entry k-1, where k is the active-core count. Entry j sits in bits [4j+3:4j]. The sum saturates at the largest ratio value.
- R4: On a tick the ratio rises by one bin when the request is high, all three over-limit flags are low, and the ratio is at least base and below the ceiling.
- R5: On a tick the ratio falls by one bin when any over-limit flag is high and the ratio is above base.
- R6: On a tick the ratio falls by one bin when it is above the ceiling, even with all flags clear.
- R7: On a tick with the request low, the ratio falls by one bin while it is above base, and then holds at base.
- R8: The ratio never steps below base. If base is raised above the ratio, the ratio rises one bin per tick toward it, whatever the request and flags.
- R9: A tick with zero active cores leaves the ratio unchanged.
- R10: Ticks occur every P clocks, where P is the period input and a value of 0 acts as 1. The first tick comes P cycles after reset is released. The ratio changes only at a tick.
- R11: The change strobe is high for exactly the one cycle in which a new ratio value first appears, and is low otherwise.
- R12: Between consecutive cycles the ratio differs by at most one bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_state | input | 8 | Per-core power-state codes, 2 bits per core |
| os_max_req | input | 1 | Operating system requests maximum performance |
| over_temp | input | 1 | Temperature above limit |
| over_curr | input | 1 | Current above limit |
| over_pwr | input | 1 | Power above limit |
| base_ratio | input | 8 | Base ratio in bins |
| boost_tbl | input | 16 | Bins of boost allowed per active-core count, 4 bits per entry |
| tick_period | input | 16 | Evaluation period in clocks |
| ratio | output | 8 | Shared core ratio in bins |
| ratio_chg | output | 1 | One-cycle pulse when the ratio changes |

## Verification
The bench goes after the ceiling falling under the present ratio when a core wakes. A design that stepped down only on a limit flag would stay stuck above the ceiling. It also checks ticks that arrive with no cores active: a design that indexed the table with a count of zero would read the wrong entry and move the ratio. It pushes a raised base against a dropped request, where a design without a floor rule would fall below base or freeze under it. Finally, it measures the spacing between strobes at a programmed period, so a counter that is off by one cycle, or a strobe that lasts longer than one cycle, shows up as a miscompare against the cycle-exact model.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned PS_W = 2;

  typedef enum logic [PS_W-1:0] {
    PS_RUN   = 2'd0,
    PS_HALT  = 2'd1,
    PS_SLEEP = 2'd2,
    PS_OFF   = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic logic is_awake(input logic [PS_W-1:0] code);
    return (code == PS_RUN) || (code == PS_HALT);
  endfunction
endpackage

// File: rtl/tsc_tick_gen.sv
module tsc_tick_gen #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] last;

  always_comb begin
    if (period == '0) last = '0;
    else              last = period - 1'b1;
  end

  assign tick = (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R10: with a period of two or more, ticks never fall on consecutive cycles
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last != '0) |=> (!tick || period != $past(period)));
endmodule

// File: rtl/tsc_active_count.sv
module tsc_active_count
  import tsc_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  localparam int unsigned CNT_W = $clog2(NCORES + 1)
) (
  input  logic [NCORES*PS_W-1:0] core_state,
  output logic [CNT_W-1:0]       active_n
);
  logic [NCORES-1:0] awake;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    assign awake[i] = is_awake(core_state[i*PS_W +: PS_W]);
  end

  always_comb begin
    active_n = '0;
    for (int i = 0; i < NCORES; i++) active_n = active_n + CNT_W'(awake[i]);
  end

  // R2: the count never exceeds the number of cores
  a_r2_count_range: assert final (active_n <= CNT_W'(NCORES));
endmodule

// File: rtl/tsc_ceiling.sv
module tsc_ceiling #(
  parameter int unsigned NCORES  = 4,
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned BOOST_W = 4,
  localparam int unsigned CNT_W  = $clog2(NCORES + 1)
) (
  input  logic [RATIO_W-1:0]        base,
  input  logic [NCORES*BOOST_W-1:0] tbl,
  input  logic [CNT_W-1:0]          active_n,
  output logic [RATIO_W-1:0]        ceil_ratio
);
  logic [BOOST_W-1:0] boost [NCORES];
  logic [BOOST_W-1:0] sel;
  logic [RATIO_W:0]   sum;

  for (genvar j = 0; j < NCORES; j++) begin : g_ent
    assign boost[j] = tbl[j*BOOST_W +: BOOST_W];
  end

  always_comb begin
    sel = '0;
    for (int j = 0; j < NCORES; j++)
      if (active_n == CNT_W'(j + 1)) sel = boost[j];
    sum = {1'b0, base} + (RATIO_W+1)'(sel);
    if (sum[RATIO_W]) ceil_ratio = '1;
    else              ceil_ratio = sum[RATIO_W-1:0];
  end

  // R3: the ceiling is never below base
  a_r3_ceiling_floor: assert final (ceil_ratio >= base);
endmodule

// File: rtl/tsc_step_decide.sv
module tsc_step_decide
  import tsc_pkg::*;
#(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned CNT_W   = 3
) (
  input  logic [RATIO_W-1:0] cur,
  input  logic [RATIO_W-1:0] base,
  input  logic [RATIO_W-1:0] ceil_ratio,
  input  logic [CNT_W-1:0]   active_n,
  input  logic               os_req,
  input  logic               any_over,
  output step_e              step
);
  always_comb begin
    step = STEP_HOLD;
    if (active_n == '0)               step = STEP_HOLD;
    else if (cur < base)              step = STEP_UP;
    else if (cur > ceil_ratio)        step = STEP_DOWN;
    else if (any_over && cur > base)  step = STEP_DOWN;
    else if (!os_req && cur > base)   step = STEP_DOWN;
    else if (os_req && !any_over && cur < ceil_ratio) step = STEP_UP;
  end
endmodule

// File: rtl/turbo_step_ctrl.sv
module turbo_step_ctrl
  import tsc_pkg::*;
#(
  parameter int unsigned NCORES   = 4,
  parameter int unsigned RATIO_W  = 8,
  parameter int unsigned BOOST_W  = 4,
  parameter int unsigned PERIOD_W = 16,
  localparam int unsigned CNT_W   = $clog2(NCORES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCORES*PS_W-1:0]      core_state,
  input  logic                        os_max_req,
  input  logic                        over_temp,
  input  logic                        over_curr,
  input  logic                        over_pwr,
  input  logic [RATIO_W-1:0]          base_ratio,
  input  logic [NCORES*BOOST_W-1:0]   boost_tbl,
  input  logic [PERIOD_W-1:0]         tick_period,
  output logic [RATIO_W-1:0]          ratio,
  output logic                        ratio_chg
);
  logic               tick;
  logic [CNT_W-1:0]   active_n;
  logic [RATIO_W-1:0] ceil_ratio;
  logic               any_over;
  step_e              step;

  assign any_over = over_temp | over_curr | over_pwr;

  tsc_tick_gen #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .period(tick_period), .tick(tick));

  tsc_active_count #(.NCORES(NCORES)) u_cnt (
    .core_state(core_state), .active_n(active_n));

  tsc_ceiling #(.NCORES(NCORES), .RATIO_W(RATIO_W), .BOOST_W(BOOST_W)) u_ceil (
    .base(base_ratio), .tbl(boost_tbl), .active_n(active_n), .ceil_ratio(ceil_ratio));

  tsc_step_decide #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_dec (
    .cur(ratio), .base(base_ratio), .ceil_ratio(ceil_ratio), .active_n(active_n),
    .os_req(os_max_req), .any_over(any_over), .step(step));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio     <= base_ratio;
      ratio_chg <= 1'b0;
    end else begin
      ratio_chg <= 1'b0;
      if (tick && step != STEP_HOLD) begin
        ratio     <= (step == STEP_UP) ? ratio + 1'b1 : ratio - 1'b1;
        ratio_chg <= 1'b1;
      end
    end
  end

  // R10: the ratio only moves on the cycle after a tick
  a_r10_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != $past(ratio)) |-> $past(tick));

  // R12: never more than one bin per cycle
  a_r12_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == $past(ratio)) || (ratio == $past(ratio) + 1'b1) || (ratio == $past(ratio) - 1'b1));

  // R11: the strobe marks exactly the cycles where the ratio differs
  a_r11_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_chg == (ratio != $past(ratio)));

  // R9: no active cores means no movement
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active_n == '0) |-> (ratio == $past(ratio)));

  // R4: a rise from at or above base needs the request and clear limits
  a_r4_rise_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio > $past(ratio) && $past(ratio) >= $past(base_ratio))
      |-> $past(os_max_req && !any_over && ratio < ceil_ratio));

  // R5: with a limit exceeded above base the ratio must fall at a tick
  a_r5_hot_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && any_over && active_n != '0 && ratio > base_ratio) |-> (ratio < $past(ratio)));
endmodule

// File: tb/sim_turbo_step_ctrl.sv
module sim_turbo_step_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  core_state = 8'h00;
  logic        os_max_req = 1'b0;
  logic        over_temp = 1'b0, over_curr = 1'b0, over_pwr = 1'b0;
  logic [7:0]  base_ratio = 8'd20;
  logic [15:0] boost_tbl = 16'h1112;
  logic [15:0] tick_period = 16'd4;
  logic [7:0]  ratio;
  logic        ratio_chg;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  logic [15:0] mcnt;
  logic [7:0]  mr;
  logic        mchg;

  always #2 clk = ~clk;

  turbo_step_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .core_state(core_state), .os_max_req(os_max_req),
    .over_temp(over_temp), .over_curr(over_curr), .over_pwr(over_pwr),
    .base_ratio(base_ratio), .boost_tbl(boost_tbl), .tick_period(tick_period),
    .ratio(ratio), .ratio_chg(ratio_chg));

  function automatic int count_active(input logic [7:0] cs);
    int n = 0;
    for (int i = 0; i < 4; i++) if (cs[2*i +: 2] < 2'd2) n++;
    return n;
  endfunction

  function automatic logic [7:0] ref_next(input logic [7:0] r, input logic [7:0] b,
      input logic [15:0] t, input logic [7:0] cs, input logic req, input logic hot);
    int n = count_active(cs);
    int c;
    if (n == 0) return r;
    c = int'(b) + int'(t[4*(n-1) +: 4]);
    if (c > 255) c = 255;
    if (r < b) return r + 8'd1;
    if (int'(r) > c) return r - 8'd1;
    if (hot && r > b) return r - 8'd1;
    if (!req && r > b) return r - 8'd1;
    if (req && !hot && int'(r) < c) return r + 8'd1;
    return r;
  endfunction

  function automatic logic [15:0] last_of(input logic [15:0] p);
    return (p == 16'd0) ? 16'd0 : p - 16'd1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= 16'd0; mr <= base_ratio; mchg <= 1'b0;
    end else begin
      mcnt <= (mcnt >= last_of(tick_period)) ? 16'd0 : mcnt + 16'd1;
      mchg <= 1'b0;
      if (mcnt >= last_of(tick_period)) begin
        mr <= ref_next(mr, base_ratio, boost_tbl, core_state, os_max_req,
                       over_temp | over_curr | over_pwr);
        mchg <= (ref_next(mr, base_ratio, boost_tbl, core_state, os_max_req,
                          over_temp | over_curr | over_pwr) != mr);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-exact comparison against the model (R11, R12 and the phase under test)
  always @(negedge clk) begin
    if (rst_n) begin
      check({phase, " ratio"}, ratio, mr);
      check({phase, " R11 strobe"}, ratio_chg, mchg);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int seed = 17;
    int t0;
    void'($urandom(seed));
    wait_cyc(3);
    check("R1 reset ratio", ratio, 20);
    check("R1 reset strobe", ratio_chg, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(1);
    check("R1 first cycle ratio", ratio, 20);

    phase = "R4";
    core_state = 8'h00; os_max_req = 1'b1;
    wait_cyc(40);
    check("R4 rise to 4-core ceiling", ratio, 21);

    phase = "R2 R3";
    core_state = {2'd3, 2'd2, 2'd3, 2'd1};
    wait_cyc(40);
    check("R3 one active core ceiling", ratio, 22);

    phase = "R6";
    core_state = {2'd3, 2'd2, 2'd0, 2'd1};
    wait_cyc(40);
    check("R6 fall to new ceiling", ratio, 21);

    phase = "R5";
    over_pwr = 1'b1;
    wait_cyc(40);
    check("R5 fall under power limit", ratio, 20);
    check("R8 stays at base", ratio, 20);

    phase = "R9";
    over_pwr = 1'b0;
    core_state = {2'd3, 2'd2, 2'd3, 2'd0};
    wait_cyc(40);
    core_state = 8'hFF; over_temp = 1'b1;
    wait_cyc(40);
    check("R9 hold with no active cores", ratio, 22);

    phase = "R7";
    over_temp = 1'b0; os_max_req = 1'b0;
    core_state = {2'd3, 2'd2, 2'd3, 2'd0};
    wait_cyc(40);
    check("R7 fall to base without request", ratio, 20);

    phase = "R8";
    base_ratio = 8'd23;
    wait_cyc(40);
    check("R8 climb to raised base", ratio, 23);

    phase = "R10";
    base_ratio = 8'd20; tick_period = 16'd6;
    while (!ratio_chg) @(negedge clk);
    t0 = 0;
    do begin @(negedge clk); t0++; end while (!ratio_chg);
    check("R10 strobe spacing", t0, 6);
    wait_cyc(40);

    phase = "R12 random";
    for (int k = 0; k < 4000; k++) begin
      if (k % 200 == 0) begin
        tick_period = 16'($urandom_range(0, 5));
        boost_tbl = 16'($urandom);
        base_ratio = 8'($urandom_range(18, 24));
      end
      if (k % 250 == 0) base_ratio = 8'd250;
      core_state = 8'($urandom);
      os_max_req = ($urandom_range(0, 3) != 0);
      over_temp = ($urandom_range(0, 7) == 0);
      over_curr = ($urandom_range(0, 9) == 0);
      over_pwr = ($urandom_range(0, 9) == 0);
      wait_cyc($urandom_range(1, 3));
    end

    summary();
    $finish;
  end
endmodule